// File: doc/BRIEF.md
# Product Term Array with Steering Allocator

This block is the combinational heart of one programmable logic block. A vector of routed input signals is expanded into literals, each input appearing once in true form and once inverted. A fixed set of product terms is then formed, each one the AND of whatever literals its configuration row selects. A steering stage gives every macrocell its own sum of products: it ORs together any chosen subset of the product terms. The same product term can feed several macrocells at once.

Configuration is static. Two wide mask vectors arrive on ports: one AND mask row for each product term, and one steering row for each macrocell. A macrocell may take at most a parameterised number of terms, 16 by default. When a row selects more than that, the block raises a per-macrocell error bit and uses only the 16 lowest-indexed selected terms. An optional output register, chosen by parameter, retimes the sums and error bits.

Top module: `pta_block`

## Requirements
- R1: Literal 2*i of the array is input i and literal 2*i+1 is its complement; AND mask bit t*72+L selects literal L for product term t, and a term is the AND of its selected literals. Inputs a term does not select have no effect on it.
- R2: A product term with no literal selected evaluates to 1.
- R3: A product term that selects both the true and the complement literal of the same input evaluates to 0.
- R4: Macrocell m outputs the OR of every product term t whose steering bit m*86+t is 1.
- R5: A macrocell with an all-zero steering row outputs 0.
- R6: One product term steered to several macrocells drives each of them at the same time.
- R7: A macrocell with 16 or fewer selected terms uses all of them, and its error bit is 0.
- R8: A macrocell with more than 16 selected terms raises its error bit and ORs only the 16 lowest-indexed selected terms.
- R9: With the output register enabled (default), sums and error bits appear one clock after the inputs that produce them.
- R10: An active-low reset clears sums and error bits at once. Release is synchronised through two flops, so the outputs first follow the inputs at the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_i | input | 36 | Routed input signals |
| and_mask_i | input | 6192 | Literal selection, 72 bits per product term |
| steer_mask_i | input | 1376 | Term selection, 86 bits per macrocell |
| sop_o | output | 16 | Sum of products per macrocell |
| ovf_o | output | 16 | Over-allocation error per macrocell |

## Verification
The embedded assertions check on every cycle that the error bits follow the population count of each steering row, that a macrocell with an empty row stays at 0, and that reset leaves the outputs cleared. Only the bench scenarios can show the actual logic values. These include which literals a term uses, shared terms, the always-true and always-false term cases, and the exclusion of the seventeenth selected term. The bench also shows the exact edge on which the outputs come out of reset.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int unsigned POLARITIES = 2;

  function automatic int unsigned count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pta_literals.sv
module pta_literals #(
  parameter int unsigned N_IN = 36
) (
  input  logic [N_IN-1:0]                       sig_i,
  output logic [pta_pkg::POLARITIES*N_IN-1:0]   lit_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_o[2*i]   = sig_i[i];
    assign lit_o[2*i+1] = ~sig_i[i];
  end
endmodule

// File: rtl/pta_terms.sv
module pta_terms #(
  parameter int unsigned N_LIT = 72,
  parameter int unsigned N_PT  = 86
) (
  input  logic [N_LIT-1:0]      lit_i,
  input  logic [N_PT*N_LIT-1:0] and_mask_i,
  output logic [N_PT-1:0]       pt_o
);
  // Unselected literals are forced to 1, so an empty row yields 1.
  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    assign pt_o[t] = &(lit_i | ~and_mask_i[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/pta_steer.sv
module pta_steer #(
  parameter int unsigned N_PT   = 86,
  parameter int unsigned N_MC   = 16,
  parameter int unsigned MAX_PT = 16
) (
  input  logic [N_PT-1:0]      pt_i,
  input  logic [N_MC*N_PT-1:0] steer_mask_i,
  output logic [N_MC-1:0]      sop_o,
  output logic [N_MC-1:0]      ovf_o
);
  localparam int unsigned CW = pta_pkg::count_bits(N_PT);

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [N_PT-1:0] row;
    logic [CW-1:0]   used;
    logic            acc;

    assign row = steer_mask_i[m*N_PT +: N_PT];

    // Walk terms in index order; only the first MAX_PT selected ones count.
    always_comb begin
      used = '0;
      acc  = 1'b0;
      for (int t = 0; t < N_PT; t++) begin
        if (row[t]) begin
          if (used < CW'(MAX_PT)) acc = acc | pt_i[t];
          used = used + CW'(1);
        end
      end
    end

    assign sop_o[m] = acc;
    assign ovf_o[m] = (used > CW'(MAX_PT));
  end
endmodule

// File: rtl/pta_block.sv
module pta_block #(
  parameter int unsigned N_IN    = 36,
  parameter int unsigned N_PT    = 86,
  parameter int unsigned N_MC    = 16,
  parameter int unsigned MAX_PT  = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [N_IN-1:0]                           sig_i,
  input  logic [N_PT*pta_pkg::POLARITIES*N_IN-1:0]  and_mask_i,
  input  logic [N_MC*N_PT-1:0]                      steer_mask_i,
  output logic [N_MC-1:0]                           sop_o,
  output logic [N_MC-1:0]                           ovf_o
);
  localparam int unsigned N_LIT = pta_pkg::POLARITIES * N_IN;

  logic [N_LIT-1:0] lit;
  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  sop_c;
  logic [N_MC-1:0]  ovf_c;

  pta_literals #(.N_IN(N_IN)) u_lit (
    .sig_i (sig_i),
    .lit_o (lit)
  );

  pta_terms #(.N_LIT(N_LIT), .N_PT(N_PT)) u_terms (
    .lit_i      (lit),
    .and_mask_i (and_mask_i),
    .pt_o       (pt)
  );

  pta_steer #(.N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT)) u_steer (
    .pt_i         (pt),
    .steer_mask_i (steer_mask_i),
    .sop_o        (sop_c),
    .ovf_o        (ovf_c)
  );

  if (REG_OUT) begin : g_reg
    logic [1:0]      rst_sync_q;
    logic            rst_n_sync;
    logic [N_MC-1:0] sop_d, sop_q;
    logic [N_MC-1:0] ovf_d, ovf_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_sync_q <= 2'b00;
      else         rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
    assign rst_n_sync = rst_sync_q[1];

    always_comb begin
      sop_d = sop_c;
      ovf_d = ovf_c;
    end

    always_ff @(posedge clk_i or negedge rst_n_sync) begin
      if (!rst_n_sync) begin
        sop_q <= '0;
        ovf_q <= '0;
      end else begin
        sop_q <= sop_d;
        ovf_q <= ovf_d;
      end
    end

    assign sop_o = sop_q;
    assign ovf_o = ovf_q;

    assert_reset_clear_R10: assert property (@(posedge clk_i)
      !rst_ni |=> (sop_q == '0 && ovf_q == '0));

    for (genvar m = 0; m < N_MC; m++) begin : g_chk
      assert_ovf_set_R8: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        ($past(rst_n_sync) && $past($countones(steer_mask_i[m*N_PT +: N_PT])) > MAX_PT)
        |-> ovf_q[m]);
      assert_ovf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        ($past(rst_n_sync) && $past($countones(steer_mask_i[m*N_PT +: N_PT])) <= MAX_PT)
        |-> !ovf_q[m]);
      assert_empty_mc_R5: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        ($past(rst_n_sync) && $past(steer_mask_i[m*N_PT +: N_PT]) == '0)
        |-> !sop_q[m]);
    end
  end else begin : g_comb
    assign sop_o = sop_c;
    assign ovf_o = ovf_c;
  end
endmodule

// File: tb/sim_pta_block.sv
`timescale 1ns/1ps
module sim_pta_block;
  localparam int NI = 36, NP = 86, NM = 16, NL = 72;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [NI-1:0]     sig_i;
  logic [NP*NL-1:0]  and_mask_i;
  logic [NM*NP-1:0]  steer_mask_i;
  logic [NM-1:0]     sop_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pta_block u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(sig_i),
    .and_mask_i(and_mask_i), .steer_mask_i(steer_mask_i),
    .sop_o(sop_o), .ovf_o(ovf_o)
  );

  // Table: input pattern -> expected sums of macrocells 0..5 (all others 0).
  localparam logic [NI-1:0] VEC_IN [8] = '{
    36'h0_0000_0000, 36'h0_0000_0001, 36'h0_0000_0003, 36'h0_0000_0004,
    36'h0_0000_0005, 36'h0_0000_0008, 36'h0_0000_000D, 36'hF_FFFF_FFF1 };
  localparam logic [5:0] VEC_EXP [8] = '{
    6'b000100, 6'b000111, 6'b000100, 6'b100110,
    6'b100111, 6'b000100, 6'b100111, 6'b000111 };

  task automatic check(input string req, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lit_sel(input int t, input int l);
    and_mask_i[t*NL + l] = 1'b1;
  endtask

  task automatic steer(input int m, input int t);
    steer_mask_i[m*NP + t] = 1'b1;
  endtask

  task automatic apply(input logic [NI-1:0] v);
    @(negedge clk_i);
    sig_i = v;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni       = 1'b0;
    sig_i        = '0;
    and_mask_i   = '0;
    steer_mask_i = '0;
    // t0 = in0 & ~in1 (R1); t1 = in2; t2 empty (R2); t3 = in3 & ~in3 (R3)
    lit_sel(0, 0); lit_sel(0, 3);
    lit_sel(1, 4);
    lit_sel(3, 6); lit_sel(3, 7);
    steer(0, 0);
    steer(1, 0); steer(1, 1);      // t0 shared by mc0 and mc1 (R6)
    steer(2, 2);
    steer(3, 3);
    steer(5, 1);                   // mc4 left empty (R5)
    // Terms 10..25 = in5; term 26 empty (always 1)
    for (int t = 10; t < 26; t++) lit_sel(t, 10);
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset sums", sop_o, '0);
    check("R10 reset errors", ovf_o, '0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    // R1 R2 R3 R4 R5 R6 R9: table walk
    for (int k = 0; k < 8; k++) begin
      apply(VEC_IN[k]);
      check("R4 table sums", sop_o, {10'b0, VEC_EXP[k]});
      check("R7 table errors", ovf_o, '0);
    end

    // R9: output holds until the next rising edge
    apply(36'h0);
    @(negedge clk_i);
    sig_i = 36'h1;
    #1;
    check("R9 before edge", sop_o, 16'h0004);
    @(posedge clk_i);
    #1;
    check("R9 after edge", sop_o, 16'h0007);

    // R8: mc7 selects terms 10..26 (17 terms); R7: mc8 selects 11..26 (16 terms)
    @(negedge clk_i);
    for (int t = 10; t <= 26; t++) steer(7, t);
    for (int t = 11; t <= 26; t++) steer(8, t);
    apply(36'h0);
    check("R8 seventeenth term dropped", sop_o & 16'h0180, 16'h0100);
    check("R8 error flag", ovf_o, 16'h0080);
    apply(36'h20);
    check("R8 lower terms still used", sop_o & 16'h0180, 16'h0180);
    check("R7 sixteen terms no error", ovf_o & 16'h0100, 16'h0000);

    // R10: asynchronous clear, then release after synchroniser
    apply(36'h0);
    #1.2;
    rst_ni = 1'b0;
    #0.5;
    check("R10 async clear", sop_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R10 first edge held", sop_o, '0);
    @(posedge clk_i); #1;
    check("R10 second edge held", sop_o, '0);
    @(posedge clk_i); #1;
    check("R10 third edge live", sop_o, 16'h0104);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule